// File: doc/BRIEF.md
# Fractional Rate Generator for a Serial Port Reference

This block turns a fixed input clock into a stream of single-cycle enable pulses. The average rate of that stream is the input rate multiplied by N/M. N and M are two independent 16-bit terms held in registers. A UART uses the stream as its reference enable, so standard baud rates can be reached from clocks that are not multiples of them. With M = 0x5F37 and N = 0x3600, for example, a 13 MHz clock gives 7.3728 MHz and a 52 MHz clock gives 29.4912 MHz. Keeping M and raising N to 0x3A98 turns 52 MHz into 32 MHz.

A small register bus gives access to three registers: control at 0xC00, M at 0xC04 and N at 0xC08. The control register holds an enable bit (bit 7) and a 2-bit reference select (bits 1:0). The select field is driven straight out to an external clock multiplexer with this encoding: 0 is the bus clock, 1 is 13 MHz, 2 is 26 MHz and 3 is the spare source. When the divider is disabled, or when N is at least M, the enable is high on every cycle and the input rate passes through.

A divide-by-16 oversampling stage follows the rate generator. It produces a second pulse once for every sixteen reference pulses, so a 52 MHz input gives a 3.25 Mbaud bit rate at full rate.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, control reads 0x0000, M reads 0x5F37 and N reads 0x3600, and `src_sel` is 0.
- R2: A write to 0xC04 or 0xC08 stores all 16 bits of `bus_wdata`, and a read returns them. A write to 0xC00 keeps bit 7 (enable) and bits 1:0 (select); bits 6:2 and 15:8 of control read as zero. A read of any other address returns zero.
- R3: `src_sel` always equals control bits 1:0.
- R4: With the enable bit set and 0 < N < M, a window of M cycles that starts one cycle after the last register write holds exactly N `ref_tick` pulses. When 2N <= M, no two of those pulses are adjacent.
- R5: With the enable bit clear, `ref_tick` is high on every cycle except the one that directly follows a register write.
- R6: With the enable bit set and N >= M, `ref_tick` is high on every cycle except the one that directly follows a register write.
- R7: With the enable bit set, N = 0 and M > 0, `ref_tick` stays low.
- R8: A write to any of the three registers clears the accumulator and the oversampling phase. In the cycle after the write, both `ref_tick` and `baud_tick` are low.
- R9: The accumulator holds one bit more than the ratio terms and stays below M. Ratios near full scale (M = 0xFFFF, N = 0xFFFE) still give exactly N pulses per M cycles.
- R10: `baud_tick` pulses only together with `ref_tick`, on every 16th reference pulse counted from the last register write.
- R11: A write with `bus_sel` low, or a write to an unmapped address, changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe; when low, an access with `bus_sel` high is a read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register at `bus_addr` (combinational) |
| src_sel | output | 2 | Reference select to the external clock multiplexer |
| ref_tick | output | 1 | Fractional enable pulse at N/M of the input rate |
| baud_tick | output | 1 | One pulse per 16 reference pulses |

## Verification
An accumulator that keeps a stale residue or wraps past 17 bits changes the pulse count of a full M-cycle window, so the error shows within one window of M cycles. If a write fails to clear the accumulator, `ref_tick` or `baud_tick` is high in the very next cycle. A wrong oversampling phase moves `baud_tick` away from the 16th reference pulse and changes its count over the same window. A mode decode error shows within two cycles, either as a missing pulse in bypass or as any pulse with N = 0.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    localparam int unsigned CTRL_OFS   = 32'h0000_0C00;
    localparam int unsigned MTERM_OFS  = 32'h0000_0C04;
    localparam int unsigned NTERM_OFS  = 32'h0000_0C08;
    localparam int unsigned EN_BIT     = 7;
    localparam int unsigned SEL_W      = 2;
    localparam logic [15:0] MTERM_RST  = 16'h5F37;
    localparam logic [15:0] NTERM_RST  = 16'h3600;

    typedef enum logic [1:0] {
        SRC_BUS  = 2'd0,
        SRC_13M  = 2'd1,
        SRC_26M  = 2'd2,
        SRC_AUX  = 2'd3
    } src_e;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
    import fbg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               cfg_en,
    output src_e               cfg_sel,
    output logic [RATIO_W-1:0] cfg_m,
    output logic [RATIO_W-1:0] cfg_n,
    output logic               wr_clr
);
    typedef struct packed {
        logic               en;
        src_e               sel;
        logic [RATIO_W-1:0] m;
        logic [RATIO_W-1:0] n;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit_ctrl, hit_m, hit_n;

    always_comb begin
        hit_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
        hit_m    = (bus_addr == ADDR_W'(MTERM_OFS));
        hit_n    = (bus_addr == ADDR_W'(NTERM_OFS));
        r_d      = r_q;
        wr_clr   = 1'b0;
        if (bus_sel && bus_wr) begin
            if (hit_ctrl) begin
                r_d.en  = bus_wdata[EN_BIT];
                r_d.sel = src_e'(bus_wdata[SEL_W-1:0]);
            end
            if (hit_m) r_d.m = bus_wdata[RATIO_W-1:0];
            if (hit_n) r_d.n = bus_wdata[RATIO_W-1:0];
            wr_clr = hit_ctrl | hit_m | hit_n;
        end
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[EN_BIT]      = r_q.en;
            bus_rdata[SEL_W-1:0]   = r_q.sel;
        end else if (hit_m) begin
            bus_rdata = DATA_W'(r_q.m);
        end else if (hit_n) begin
            bus_rdata = DATA_W'(r_q.n);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.en  <= 1'b0;
            r_q.sel <= SRC_BUS;
            r_q.m   <= RATIO_W'(MTERM_RST);
            r_q.n   <= RATIO_W'(NTERM_RST);
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_en  = r_q.en;
    assign cfg_sel = r_q.sel;
    assign cfg_m   = r_q.m;
    assign cfg_n   = r_q.n;
endmodule

// File: rtl/fbg_accum.sv
module fbg_accum #(
    parameter int unsigned RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [RATIO_W-1:0] m,
    input  logic [RATIO_W-1:0] n,
    output logic               step,
    output logic               tick,
    output logic [RATIO_W:0]   acc
);
    localparam int unsigned ACC_W = RATIO_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             tick;
    } acc_t;

    acc_t a_d, a_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        a_d  = a_q;
        sum  = a_q.acc + {1'b0, n};
        step = 1'b0;
        if (clr) begin
            a_d.acc = '0;
        end else if (!en || (n >= m)) begin
            a_d.acc = '0;
            step    = 1'b1;
        end else if (sum >= {1'b0, m}) begin
            a_d.acc = sum - {1'b0, m};
            step    = 1'b1;
        end else begin
            a_d.acc = sum;
        end
        a_d.tick = step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign tick = a_q.tick;
    assign acc  = a_q.acc;
endmodule

// File: rtl/fbg_os_div.sv
module fbg_os_div #(
    parameter int unsigned OS_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic baud
);
    localparam logic [OS_LOG2-1:0] LAST = '1;

    typedef struct packed {
        logic [OS_LOG2-1:0] cnt;
        logic               baud;
    } os_t;

    os_t o_d, o_q;

    always_comb begin
        o_d      = o_q;
        o_d.baud = 1'b0;
        if (clr) begin
            o_d.cnt = '0;
        end else if (step) begin
            o_d.baud = (o_q.cnt == LAST);
            o_d.cnt  = o_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign baud = o_q.baud;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned RATIO_W = 16,
    parameter int unsigned OS_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [1:0]        src_sel,
    output logic              ref_tick,
    output logic              baud_tick
);
    logic               cfg_en;
    src_e               cfg_sel;
    logic [RATIO_W-1:0] cfg_m;
    logic [RATIO_W-1:0] cfg_n;
    logic               wr_clr;
    logic               step;
    logic [RATIO_W:0]   acc_val;

    fbg_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .RATIO_W (RATIO_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_en    (cfg_en),
        .cfg_sel   (cfg_sel),
        .cfg_m     (cfg_m),
        .cfg_n     (cfg_n),
        .wr_clr    (wr_clr)
    );

    fbg_accum #(
        .RATIO_W (RATIO_W)
    ) accum_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_clr),
        .en    (cfg_en),
        .m     (cfg_m),
        .n     (cfg_n),
        .step  (step),
        .tick  (ref_tick),
        .acc   (acc_val)
    );

    fbg_os_div #(
        .OS_LOG2 (OS_LOG2)
    ) os_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_clr),
        .step  (step),
        .baud  (baud_tick)
    );

    assign src_sel = cfg_sel;
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker
    import fbg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned RATIO_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               ref_tick,
    input logic               baud_tick,
    input logic               en,
    input logic [RATIO_W-1:0] m,
    input logic [RATIO_W-1:0] n,
    input logic [RATIO_W:0]   acc
);
    logic wr_hit;
    assign wr_hit = bus_sel && bus_wr &&
                    ((bus_addr == ADDR_W'(CTRL_OFS)) ||
                     (bus_addr == ADDR_W'(MTERM_OFS)) ||
                     (bus_addr == ADDR_W'(NTERM_OFS)));

    AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_W'(CTRL_OFS)) |-> (bus_rdata[6:2] == '0)); // R2
    AST_BYPASS_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_hit) |=> ref_tick); // R5
    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && n >= m && !wr_hit) |=> ref_tick); // R6
    AST_ZERO_N_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && n == '0 && m != '0 && !wr_hit) |=> !ref_tick); // R7
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (!ref_tick && !baud_tick && acc == '0)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (n != '0 && n < m) |-> (acc < {1'b0, m})); // R9
    AST_BAUD_WITH_REF: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> ref_tick); // R10
endmodule

bind frac_baud_gen fbg_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RATIO_W (RATIO_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ref_tick  (ref_tick),
    .baud_tick (baud_tick),
    .en        (cfg_en),
    .m         (cfg_m),
    .n         (cfg_n),
    .acc       (acc_val)
);

// File: tb/frac_baud_gen_tb_top.sv
module frac_baud_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  src_sel;
    logic        ref_tick;
    logic        baud_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    frac_baud_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_sel   (src_sel),
        .ref_tick  (ref_tick),
        .baud_tick (baud_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [15:0] d, input logic sel = 1'b1);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic count_window(input int cycles, output int nref, output int nbaud, output bit adj);
        bit prev = 1'b0;
        nref = 0; nbaud = 0; adj = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            nref  += int'(ref_tick);
            nbaud += int'(baud_tick);
            if (ref_tick && prev) adj = 1'b1;
            prev = ref_tick;
        end
    endtask

    task automatic t_reset;
        logic [15:0] d;
        bus_read(12'hC00, d); check("R1 ctrl", d, 16'h0000);
        bus_read(12'hC04, d); check("R1 M", d, 16'h5F37);
        bus_read(12'hC08, d); check("R1 N", d, 16'h3600);
        check("R1 src_sel", src_sel, 0);
    endtask

    task automatic t_regs;
        logic [15:0] d;
        bus_write(12'hC00, 16'hFFFF);
        bus_read(12'hC00, d); check("R2 ctrl reserved bits", d, 16'h0083);
        check("R3 src_sel=3", src_sel, 3);
        bus_write(12'hC00, 16'h0081);
        check("R3 src_sel=1", src_sel, 1);
        bus_write(12'hC00, 16'h0002);
        check("R3 src_sel=2", src_sel, 2);
        bus_write(12'hC04, 16'hA5A5);
        bus_read(12'hC04, d); check("R2 M readback", d, 16'hA5A5);
        bus_write(12'hC08, 16'h1234);
        bus_read(12'hC08, d); check("R2 N readback", d, 16'h1234);
        bus_read(12'hC10, d); check("R2 unmapped read", d, 0);
    endtask

    task automatic t_ignore;
        logic [15:0] d;
        bus_write(12'hC0C, 16'hBEEF);
        bus_write(12'hC04, 16'h0F0F, 1'b0);
        bus_write(12'h004, 16'h0F0F);
        bus_read(12'hC04, d); check("R11 M unchanged", d, 16'hA5A5);
        bus_read(12'hC08, d); check("R11 N unchanged", d, 16'h1234);
        bus_read(12'hC00, d); check("R11 ctrl unchanged", d, 16'h0002);
    endtask

    task automatic t_ratio(input string req, input int m, input int n);
        int nr, nb; bit adj;
        bus_write(12'hC04, 16'(m));
        bus_write(12'hC08, 16'(n));
        bus_write(12'hC00, 16'h0080);
        check({req, " R8 tick low after write"}, int'(ref_tick), 0);
        count_window(m, nr, nb, adj);
        check({req, " R4 ref pulses"}, nr, n);
        check({req, " R10 baud pulses"}, nb, n / 16);
        if (2 * n <= m) check({req, " R4 single-cycle pulses"}, int'(adj), 0);
    endtask

    task automatic t_bypass;
        int nr, nb; bit adj;
        bus_write(12'hC00, 16'h0000);
        check("R8 ref low after write", int'(ref_tick), 0);
        check("R8 baud low after write", int'(baud_tick), 0);
        count_window(100, nr, nb, adj);
        check("R5 bypass ref", nr, 100);
        check("R10 bypass baud every 16th", nb, 6);
    endtask

    task automatic t_full;
        int nr, nb; bit adj;
        bus_write(12'hC04, 16'h0100);
        bus_write(12'hC08, 16'h0100);
        bus_write(12'hC00, 16'h0080);
        count_window(50, nr, nb, adj);
        check("R6 N==M full rate", nr, 50);
        bus_write(12'hC08, 16'h0200);
        count_window(50, nr, nb, adj);
        check("R6 N>M full rate", nr, 50);
    endtask

    task automatic t_zero;
        int nr, nb; bit adj;
        bus_write(12'hC04, 16'h0100);
        bus_write(12'hC08, 16'h0000);
        bus_write(12'hC00, 16'h0080);
        count_window(500, nr, nb, adj);
        check("R7 N=0 silent", nr, 0);
        check("R7 N=0 no baud", nb, 0);
    endtask

    initial begin
        #(20 * 195000);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 reset bypass", int'(ref_tick), 1);
        t_reset();
        t_regs();
        t_ignore();
        t_bypass();
        t_full();
        t_zero();
        t_ratio("13/26 MHz ratio", 16'h5F37, 16'h3600);
        t_ratio("32 MHz ratio", 16'h5F37, 16'h3A98);
        t_ratio("sparse ratio", 1000, 7);
        t_ratio("half ratio", 100, 48);
        t_ratio("R9 full scale", 16'hFFFF, 16'hFFFE);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule